// File: doc/BRIEF.md
# Direction-Overridable GPIO Port

This block is one 8-bit slice of a general-purpose I/O port. Software reaches it over a simple register bus. Three registers are mapped on that bus:

- a direction register, with one bit per pin;
- an output-data register, which holds the values driven on pins that software controls;
- a read-only pin-level register, which shows every pad after a two-flop synchronizer.

The pin-level register shows every pin, including pins that are driving, so software can compare what it drives against what the pad actually carries.

Three peripheral sources can take direction control away from software while they are enabled: a serial peripheral block, a serial transmit channel and a serial receive channel. Parameter masks set which pins each source owns. Where masks overlap, the serial peripheral block beats the serial channels, and transmit beats receive. Ownership is decided combinationally from the enables. Clearing an enable therefore hands the pin back to the direction register in the same cycle.

Toward the pads the block drives a per-pin output enable and a per-pin output value. From the pads it takes the raw input level.

Top module: `gpio_dirport`

## Requirements
- R1: A read at offset IN_OFS (default 0x379) returns the pad input levels as sampled at the rising clock edge two edges before the read's sampling edge. This holds for pins that are outputs too. The synchronizer is not reset.
- R2: A write to IN_OFS changes no register. Afterwards the direction and output-data registers read back unchanged, and the pad outputs are unchanged.
- R3: The direction register at DIR_OFS (default 0x37A) resets to 0x00. A write to it takes effect at the next rising edge, and it reads back whatever was last written. The output-data register at DAT_OFS (default 0x378) also resets to 0x00 and reads back in the same way.
- R4: On a pin that no enabled source owns, pad_oe[i] equals direction bit i. A 1 means output and a 0 means input.
- R5: While spi_en is 1, every pin in SPI_MASK has pad_oe[i] = spi_dir[i] and pad_do[i] = spi_dout[i], whatever its direction bit holds.
- R6: While tx_en is 1, every pin in TX_MASK that the serial peripheral block does not own has pad_oe[i] = 1 and pad_do[i] = tx_dout[i].
- R7: While rx_en is 1, every pin in RX_MASK that neither spi nor tx owns has pad_oe[i] = 0.
- R8: On a pin that lies in SPI_MASK and also in a serial mask, an enabled serial peripheral block wins over the serial channels.
- R9: When an enable drops, the affected pins follow the direction register in the same cycle. No clock edge is needed.
- R10: With rd_en low, rd_data is 0x00. A read at any offset other than the three mapped ones also returns 0x00.
- R11: On a pin that no enabled spi or tx source owns, pad_do[i] equals bit i of the output-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, single cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, single cycle |
| rd_data | output | 8 | Read data, combinational while rd_en is high |
| pad_di | input | 8 | Raw levels from the pad input buffers |
| pad_oe | output | 8 | Per-pin output enable toward the pads |
| pad_do | output | 8 | Per-pin output value toward the pads |
| spi_en | input | 1 | Serial peripheral block enabled |
| spi_dir | input | 8 | Per-pin direction requested by the serial peripheral block (1 = output) |
| spi_dout | input | 8 | Per-pin output value from the serial peripheral block |
| tx_en | input | 1 | Serial transmit channel enabled |
| tx_dout | input | 8 | Per-pin output value from the transmit channel |
| rx_en | input | 1 | Serial receive channel enabled |

## Verification
Pad controls follow the enables and the registers with no delay at all. Because of that, the bench compares pad_oe and pad_do against its reference model on every clock, one nanosecond before the next rising edge, well after the inputs have changed at the falling edge.

Register writes become visible only after the rising edge that follows the strobe. Every read-back is therefore issued on a later cycle and checked combinationally just after the falling edge.

The pin-level register lags the pads by two rising edges. The bench keeps a two-deep history of pad samples taken at each rising edge and expects the older of the two. One check, taken straight after a pad change, confirms that the old value is still shown.

// File: rtl/gpio_dirport_pkg.sv
package gpio_dirport_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2,
    OWN_SPI  = 2'd3
  } owner_e;

  // Highest-priority active source for one pin.
  function automatic owner_e pick_owner(logic spi_a, logic tx_a, logic rx_a);
    if (spi_a)     return OWN_SPI;
    else if (tx_a) return OWN_TX;
    else if (rx_a) return OWN_RX;
    else           return OWN_NONE;
  endfunction

  function automatic logic resolve_oe(owner_e o, logic spi_d, logic dir_bit);
    case (o)
      OWN_SPI: return spi_d;
      OWN_TX:  return 1'b1;
      OWN_RX:  return 1'b0;
      default: return dir_bit;
    endcase
  endfunction

  function automatic logic resolve_do(owner_e o, logic spi_v, logic tx_v, logic dat_bit);
    case (o)
      OWN_SPI: return spi_v;
      OWN_TX:  return tx_v;
      default: return dat_bit;
    endcase
  endfunction

endpackage

// File: rtl/gpio_dirport_sync.sv
module gpio_dirport_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  // Deliberately not reset: the synchronized value simply tracks the pads.
  always_ff @(posedge clk) stg[0] <= din;

  for (genvar j = 1; j < STAGES; j++) begin : g_stage
    always_ff @(posedge clk) stg[j] <= stg[j-1];
  end

  assign dout = stg[LAST];
endmodule

// File: rtl/gpio_dirport_regs.sv
module gpio_dirport_regs #(
  parameter int          WIDTH   = 8,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] IN_OFS  = 12'h379,
  parameter logic [11:0] DIR_OFS = 12'h37A,
  parameter logic [11:0] DAT_OFS = 12'h378
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [WIDTH-1:0]  in_val,
  output logic [WIDTH-1:0]  rd_data,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  dat_q
);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(IN_OFS);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DAT_OFS);

  logic hit_in, hit_dir, hit_dat;

  assign hit_in  = (addr == A_IN);
  assign hit_dir = (addr == A_DIR);
  assign hit_dat = (addr == A_DAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else if (wr_en) begin
      if (hit_dir) dir_q <= wr_data;
      if (hit_dat) dat_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (hit_in)       rd_data = in_val;
      else if (hit_dir) rd_data = dir_q;
      else if (hit_dat) rd_data = dat_q;
    end
  end
endmodule

// File: rtl/gpio_dirport_pinmux.sv
module gpio_dirport_pinmux
  import gpio_dirport_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] SPI_MASK = 8'h0F,
  parameter logic [WIDTH-1:0] TX_MASK  = 8'h12,
  parameter logic [WIDTH-1:0] RX_MASK  = 8'h24
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dat_q,
  input  logic             spi_en,
  input  logic [WIDTH-1:0] spi_dir,
  input  logic [WIDTH-1:0] spi_dout,
  input  logic             tx_en,
  input  logic [WIDTH-1:0] tx_dout,
  input  logic             rx_en,
  output logic [WIDTH-1:0] spi_act,
  output logic [WIDTH-1:0] tx_act,
  output logic [WIDTH-1:0] rx_act,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_do
);
  assign spi_act = SPI_MASK & {WIDTH{spi_en}};
  assign tx_act  = TX_MASK  & {WIDTH{tx_en}};
  assign rx_act  = RX_MASK  & {WIDTH{rx_en}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    owner_e own;
    assign own       = pick_owner(spi_act[i], tx_act[i], rx_act[i]);
    assign pad_oe[i] = resolve_oe(own, spi_dir[i], dir_q[i]);
    assign pad_do[i] = resolve_do(own, spi_dout[i], tx_dout[i], dat_q[i]);
  end
endmodule

// File: rtl/gpio_dirport.sv
module gpio_dirport #(
  parameter int          WIDTH    = 8,
  parameter int          ADDR_W   = 12,
  parameter int          SYNC_LEN = 2,
  parameter logic [11:0] IN_OFS   = 12'h379,
  parameter logic [11:0] DIR_OFS  = 12'h37A,
  parameter logic [11:0] DAT_OFS  = 12'h378,
  parameter logic [7:0]  SPI_MASK = 8'h0F,
  parameter logic [7:0]  TX_MASK  = 8'h12,
  parameter logic [7:0]  RX_MASK  = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  pad_di,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_do,
  input  logic              spi_en,
  input  logic [WIDTH-1:0]  spi_dir,
  input  logic [WIDTH-1:0]  spi_dout,
  input  logic              tx_en,
  input  logic [WIDTH-1:0]  tx_dout,
  input  logic              rx_en
);
  // Named internal nets, exposed for the bound checker.
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] dir_q, dat_q;
  logic [WIDTH-1:0] spi_act, tx_act, rx_act;

  gpio_dirport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk  (clk),
    .din  (pad_di),
    .dout (in_sync)
  );

  gpio_dirport_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W),
    .IN_OFS(IN_OFS), .DIR_OFS(DIR_OFS), .DAT_OFS(DAT_OFS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .in_val  (in_sync),
    .rd_data (rd_data),
    .dir_q   (dir_q),
    .dat_q   (dat_q)
  );

  gpio_dirport_pinmux #(
    .WIDTH(WIDTH),
    .SPI_MASK(WIDTH'(SPI_MASK)), .TX_MASK(WIDTH'(TX_MASK)), .RX_MASK(WIDTH'(RX_MASK))
  ) u_pinmux (
    .dir_q    (dir_q),
    .dat_q    (dat_q),
    .spi_en   (spi_en),
    .spi_dir  (spi_dir),
    .spi_dout (spi_dout),
    .tx_en    (tx_en),
    .tx_dout  (tx_dout),
    .rx_en    (rx_en),
    .spi_act  (spi_act),
    .tx_act   (tx_act),
    .rx_act   (rx_act),
    .pad_oe   (pad_oe),
    .pad_do   (pad_do)
  );
endmodule

// File: rtl/gpio_dirport_chk.sv
module gpio_dirport_chk #(
  parameter int          WIDTH   = 8,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] IN_OFS  = 12'h379,
  parameter logic [11:0] DIR_OFS = 12'h37A,
  parameter logic [11:0] DAT_OFS = 12'h378
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [WIDTH-1:0]  wr_data,
  input logic              rd_en,
  input logic [WIDTH-1:0]  rd_data,
  input logic [WIDTH-1:0]  pad_di,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  spi_dir,
  input logic [WIDTH-1:0]  spi_act,
  input logic [WIDTH-1:0]  tx_act,
  input logic [WIDTH-1:0]  rx_act,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  dat_q
);
  logic [1:0] since_rst;
  logic       mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  assign mapped = (addr == ADDR_W'(IN_OFS)) || (addr == ADDR_W'(DIR_OFS)) ||
                  (addr == ADDR_W'(DAT_OFS));

  p_in_lag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2 && rd_en && addr == ADDR_W'(IN_OFS)) |-> rd_data == $past(pad_di, 2));

  p_in_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && wr_en && addr == ADDR_W'(IN_OFS)) |=> ($stable(dir_q) && $stable(dat_q)));

  p_dir_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(DIR_OFS)) |=> dir_q == $past(wr_data));

  p_free_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~(spi_act | tx_act | rx_act)) == '0);

  p_spi_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ spi_dir) & spi_act) == '0);

  p_tx_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (~pad_oe & tx_act & ~spi_act) == '0);

  p_rx_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & rx_act & ~spi_act & ~tx_act) == '0);

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !mapped) |-> rd_data == '0);
endmodule

bind gpio_dirport gpio_dirport_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W),
  .IN_OFS(IN_OFS), .DIR_OFS(DIR_OFS), .DAT_OFS(DAT_OFS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .pad_di  (pad_di),
  .pad_oe  (pad_oe),
  .spi_dir (spi_dir),
  .spi_act (spi_act),
  .tx_act  (tx_act),
  .rx_act  (rx_act),
  .dir_q   (dir_q),
  .dat_q   (dat_q)
);

// File: tb/gpio_dirport_tb.sv
module gpio_dirport_tb;
  localparam logic [11:0] A_IN  = 12'h379;
  localparam logic [11:0] A_DIR = 12'h37A;
  localparam logic [11:0] A_DAT = 12'h378;
  localparam logic [7:0]  M_SPI = 8'h0F;
  localparam logic [7:0]  M_TX  = 8'h12;
  localparam logic [7:0]  M_RX  = 8'h24;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = '0, rd_data, pad_di = '0, pad_oe, pad_do;
  logic spi_en = 0, tx_en = 0, rx_en = 0;
  logic [7:0] spi_dir = '0, spi_dout = '0, tx_dout = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  gpio_dirport u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_di(pad_di), .pad_oe(pad_oe),
    .pad_do(pad_do), .spi_en(spi_en), .spi_dir(spi_dir), .spi_dout(spi_dout),
    .tx_en(tx_en), .tx_dout(tx_dout), .rx_en(rx_en)
  );

  always #4 clk = ~clk;

  // Reference model state
  logic [7:0] m_dir = '0, m_dat = '0;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0;
      m_dat = '0;
    end else if (wr_en) begin
      if (addr == A_DIR) m_dir = wr_data;
      else if (addr == A_DAT) m_dat = wr_data;
    end
  end

  always @(posedge clk) begin
    hist.push_front(pad_di);
    if (hist.size() > 2) void'(hist.pop_back());
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-pin expectation and owning requirement, written as one decision chain.
  function automatic string pin_tag(int i);
    if (spi_en && M_SPI[i]) return (tx_en && M_TX[i]) || (rx_en && M_RX[i]) ? "R8" : "R5";
    if (tx_en && M_TX[i]) return "R6";
    if (rx_en && M_RX[i]) return "R7";
    return "R4";
  endfunction

  always @(negedge clk) begin
    #3;
    for (int i = 0; i < 8; i++) begin
      logic eo, ed;
      if (spi_en && M_SPI[i])    begin eo = spi_dir[i]; ed = spi_dout[i]; end
      else if (tx_en && M_TX[i]) begin eo = 1'b1;       ed = tx_dout[i];  end
      else if (rx_en && M_RX[i]) begin eo = 1'b0;       ed = m_dat[i];    end
      else                       begin eo = m_dir[i];   ed = m_dat[i];    end
      check({pin_tag(i), " oe"}, {7'd0, pad_oe[i]}, {7'd0, eo});
      check((spi_en && M_SPI[i]) || (tx_en && M_TX[i]) ? {pin_tag(i), " do"} : "R11 do",
            {7'd0, pad_do[i]}, {7'd0, ed});
    end
  end

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_read(input string tag, input logic [11:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; rd_en = 1;
    #1 check(tag, rd_data, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic read_in(input string tag);
    @(negedge clk); addr = A_IN; rd_en = 1;
    #1 check(tag, rd_data, hist[1]);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset values
    bus_read("R3 dir reset", A_DIR, 8'h00);
    bus_read("R3 dat reset", A_DAT, 8'h00);
    // R10 idle and unmapped reads
    #1 check("R10 idle rd_data", rd_data, 8'h00);
    bus_read("R10 unmapped", 12'h100, 8'h00);
    bus_read("R10 unmapped near", 12'h37B, 8'h00);
    // R1 synchronizer lag
    @(negedge clk); pad_di = 8'hA5;
    repeat (3) @(negedge clk);
    read_in("R1 settled");
    @(negedge clk); pad_di = 8'h3C;
    addr = A_IN; rd_en = 1;
    @(posedge clk); #1 check("R1 one edge old", rd_data, 8'hA5);
    @(negedge clk); rd_en = 0;
    read_in("R1 after change");
    // R3/R4/R11 register-driven pins
    bus_write(A_DIR, 8'hF0);
    bus_read("R3 dir readback", A_DIR, 8'hF0);
    bus_write(A_DAT, 8'h96);
    bus_read("R3 dat readback", A_DAT, 8'h96);
    @(negedge clk); #1 check("R4 oe follows dir", pad_oe, 8'hF0);
    check("R11 do follows dat", pad_do, 8'h96);
    // R1 loopback on output pins
    @(negedge clk); pad_di = 8'h5A;
    repeat (3) @(negedge clk);
    read_in("R1 output pin level");
    // R2 write to input register ignored
    bus_write(A_IN, 8'hFF);
    bus_read("R2 dir kept", A_DIR, 8'hF0);
    bus_read("R2 dat kept", A_DAT, 8'h96);
    read_in("R2 input still pins");
    #1 check("R2 oe kept", pad_oe, 8'hF0);
    // R5/R8 serial peripheral block with overlapping channels
    @(negedge clk); spi_dir = 8'h05; spi_dout = 8'h0A; tx_dout = 8'hFF;
    spi_en = 1; tx_en = 1; rx_en = 1;
    #1 check("R8 spi wins oe", pad_oe, 8'hF5 & ~8'h20 | 8'h10);
    check("R5 spi do", pad_do & 8'h0F, 8'h0A);
    repeat (4) @(negedge clk);
    // R6/R7 serial channels own their pins
    spi_en = 0;
    bus_write(A_DIR, 8'h24);
    #1 check("R6 R7 channels", pad_oe & 8'h36, 8'h12);
    check("R6 tx do", pad_do & 8'h12, 8'h12);
    // R9 immediate return on disable
    @(negedge clk); tx_en = 0; rx_en = 0;
    #1 check("R9 dir regains pins", pad_oe, 8'h24);
    check("R9 dat regains pins", pad_do, 8'h96);
    // Mixed patterns
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      spi_en = k[0]; tx_en = k[1]; rx_en = k[2];
      spi_dir = 8'(k * 37); spi_dout = 8'(k * 91); tx_dout = 8'(~k);
      pad_di = 8'(k * 13);
      if (k % 5 == 0) bus_write(A_DIR, 8'(k * 29));
      if (k % 7 == 0) bus_write(A_DAT, 8'(k * 53));
    end
    read_in("R1 mixed");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule